// File: doc/BRIEF.md
# Oversampled Serial Receiver with Two-Entry Buffer

This block receives asynchronous serial frames on a single data line. An enable-qualified tick at sixteen times the bit rate drives the receiver. The receiver waits for a falling line and confirms a start bit. It then takes each data bit least-significant first, and optionally a parity bit. The frame ends on the first stop bit. Each bit is decided by a majority vote of three samples around the middle of its bit period, which filters short noise pulses.

A completed frame goes into a two-entry buffer. The frame's error indications travel with it. The consumer sees the oldest entry on the read-data port while the receive-complete flag is high, and takes it with a one-cycle read strobe. Three sticky error bits report framing, parity and overflow. Each is cleared by writing a one to its clear bit.

A mode input chooses how overflow is reported. It is either raised at once, or attached to the newest buffered frame and shown when that frame reaches the head. Dropping the enable aborts any frame in progress, empties the buffer and clears all error bits.

Top module: `serial_rx2`

## Requirements
- R1: In idle, a tick that sees the line low starts a frame, with that tick counted as tick 0. If the vote of ticks 7, 8 and 9 of the start bit is high, the receiver returns to idle and no frame is stored.
- R2: Every bit value is the majority of the line samples at oversample ticks 7, 8 and 9 of its 16-tick period. A sample at any other tick has no effect, and neither does a single disagreeing sample among the three.
- R3: Data bits arrive least-significant first. At tick 9 of the first stop bit the frame is stored, and rx_done goes high with the oldest stored frame on rd_data.
- R4: A second stop bit is not required. A start bit that directly follows one stop bit is received as a new frame.
- R5: The buffer holds two frames in arrival order, and rx_done is high while at least one is held. Each rd_stb removes the oldest frame. rd_stb on an empty buffer has no effect.
- R6: A frame whose voted stop bit is 0 is still stored. err_ferr becomes set when that frame is the oldest held entry, and not before.
- R7: With par_en=1 a parity bit follows the data bits. The expected bit is the XOR of the data bits for par_odd=0, and its inverse for par_odd=1. A mismatch sets err_perr when that frame is the oldest held entry.
- R8: err_clr bit 0 clears err_ferr, bit 1 clears err_perr and bit 2 clears err_ovf. A clear bit of 0 leaves its error bit unchanged.
- R9: With ovf_imm=1, a frame that completes while two frames are held, with no read in the same cycle, is dropped. err_ovf is set in the next cycle.
- R10: With ovf_imm=0, the overflowing frame is dropped and the overflow is attached to the newer held frame. err_ovf stays low until the older frame is read, then rises.
- R11: While rx_en=0, the frame in progress is abandoned, the buffer is emptied and all three error bits are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low flushes and clears |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| par_en | input | 1 | Frame carries a parity bit |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| ovf_imm | input | 1 | Overflow reported immediately (1) or with the data (0) |
| rd_stb | input | 1 | Removes the oldest buffered frame |
| err_clr | input | 3 | Write-one-to-clear: {overflow, parity, frame} |
| rd_data | output | DATA_W | Oldest buffered frame |
| rx_done | output | 1 | At least one frame is buffered |
| err_ferr | output | 1 | Sticky frame error |
| err_perr | output | 1 | Sticky parity error |
| err_ovf | output | 1 | Sticky overflow |

## Verification
The hardest behaviour to reach from the ports is deferred overflow. To get there, the buffer must be full and a third frame must complete before any read, and the flag must be seen to stay low until the older entry leaves. The bench sends three frames back to back without reading. It observes err_ovf before and after one read strobe, and confirms that the third frame never appears. A framing error is carried the same way: a bad-stop frame queued behind a good one must not raise err_ferr until the good one is read. The majority filter is swept with noise masks over all sixteen sample positions of every data bit.

// File: rtl/serial_rx2.sv
module serial_rx2 #(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              ovf_imm,
  input  logic              rd_stb,
  input  logic [2:0]        err_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_done,
  output logic              err_ferr,
  output logic              err_perr,
  output logic              err_ovf
);
  localparam int CW = $clog2(OS_RATE);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] S_LO  = CW'(OS_RATE / 2 - 1);
  localparam logic [CW-1:0] S_HI  = CW'(OS_RATE / 2 + 1);
  localparam logic [CW-1:0] C_END = CW'(OS_RATE - 1);
  localparam logic [BW-1:0] B_END = BW'(DATA_W - 1);

  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP} st_t;

  st_t               st;
  logic [1:0]        sync;
  logic [CW-1:0]     tcnt;
  logic [BW-1:0]     bidx;
  logic [1:0]        smp;
  logic [DATA_W-1:0] shreg;
  logic              perr_q;
  logic              rxs, vote, push;

  assign rxs  = sync[1];
  assign vote = (smp[1] & smp[0]) | (smp[1] & rxs) | (smp[0] & rxs);
  assign push = rx_en && os_tick && st == STOP && tcnt == S_HI;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; tcnt <= '0; bidx <= '0; smp <= '0; shreg <= '0; perr_q <= 1'b0;
    end else if (!rx_en) begin
      st <= IDLE; tcnt <= '0;
    end else if (os_tick) begin
      tcnt <= (tcnt == C_END) ? '0 : tcnt + 1'b1;
      if (tcnt >= S_LO && tcnt < S_HI) smp <= {smp[0], rxs};
      case (st)
        IDLE: begin
          tcnt <= rxs ? '0 : CW'(1);
          if (!rxs) st <= START;
        end
        START: begin
          perr_q <= 1'b0;
          bidx   <= '0;
          if (tcnt == S_HI && vote) begin
            st <= IDLE; tcnt <= '0;
          end else if (tcnt == C_END) st <= DATA;
        end
        DATA: begin
          if (tcnt == S_HI) shreg <= {vote, shreg[DATA_W-1:1]};
          if (tcnt == C_END) begin
            if (bidx == B_END) st <= par_en ? PAR : STOP;
            else bidx <= bidx + 1'b1;
          end
        end
        PAR: begin
          if (tcnt == S_HI) perr_q <= vote ^ (^shreg) ^ par_odd;
          if (tcnt == C_END) st <= STOP;
        end
        STOP: if (tcnt == S_HI) begin
          st <= IDLE; tcnt <= '0;
        end
        default: st <= IDLE;
      endcase
    end
  end

  logic [DATA_W-1:0] mem [2];
  logic [1:0] t_f, t_p, t_o, cnt;
  logic       head, pop, full, accept, widx, ovf_now, xf, xp, xo;

  assign pop     = rd_stb && cnt != 2'd0;
  assign full    = cnt == 2'd2;
  assign accept  = push && (!full || pop);
  assign ovf_now = push && full && !pop;
  assign widx    = head ^ (cnt == 2'd1);
  assign xf      = cnt != 2'd0 && t_f[head];
  assign xp      = cnt != 2'd0 && t_p[head];
  assign xo      = cnt != 2'd0 && t_o[head];
  assign rd_data = mem[head];
  assign rx_done = cnt != 2'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; head <= 1'b0; t_f <= '0; t_p <= '0; t_o <= '0;
      mem[0] <= '0; mem[1] <= '0;
    end else if (!rx_en) begin
      cnt <= '0; head <= 1'b0; t_f <= '0; t_p <= '0; t_o <= '0;
    end else begin
      if (cnt != 2'd0) begin
        t_f[head] <= 1'b0; t_p[head] <= 1'b0; t_o[head] <= 1'b0;
      end
      if (pop) head <= ~head;
      cnt <= cnt + {1'b0, accept} - {1'b0, pop};
      if (accept) begin
        mem[widx] <= shreg;
        t_f[widx] <= ~vote;
        t_p[widx] <= par_en & perr_q;
        t_o[widx] <= 1'b0;
      end
      if (ovf_now && !ovf_imm) t_o[~head] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !rx_en) begin
      err_ferr <= 1'b0; err_perr <= 1'b0; err_ovf <= 1'b0;
    end else begin
      err_ferr <= (err_ferr & ~err_clr[0]) | xf;
      err_perr <= (err_perr & ~err_clr[1]) | xp;
      err_ovf  <= (err_ovf  & ~err_clr[2]) | xo | (ovf_now & ovf_imm);
    end
  end
endmodule

module serial_rx2_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       rd_stb,
  input logic       ovf_imm,
  input logic [2:0] err_clr,
  input logic       rx_done,
  input logic       err_ferr,
  input logic       err_perr,
  input logic       err_ovf,
  input logic       push,
  input logic       full,
  input logic       xf,
  input logic       xp,
  input logic       xo
);
  a_r11_disable_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_done && !err_ferr && !err_perr && !err_ovf);
  a_r9_immediate_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && ovf_imm && push && full && !rd_stb |=> err_ovf);
  a_r10_deferred_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && !ovf_imm && !err_ovf && push && full && !rd_stb && !xo |=> !err_ovf);
  a_r8_clear_ferr: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && err_clr[0] && !xf |=> !err_ferr);
  a_r8_clear_perr: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && err_clr[1] && !xp |=> !err_perr);
  a_r5_hold_done: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && rx_done && !rd_stb |=> rx_done);
  a_r5_empty_stays: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && !rx_done && !push |=> !rx_done);
endmodule

bind serial_rx2 serial_rx2_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_stb(rd_stb), .ovf_imm(ovf_imm),
  .err_clr(err_clr), .rx_done(rx_done), .err_ferr(err_ferr), .err_perr(err_perr),
  .err_ovf(err_ovf), .push(push), .full(full), .xf(xf), .xp(xp), .xo(xo)
);

// File: tb/serial_rx2_bench.sv
module serial_rx2_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b1;
  logic       os_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       ovf_imm = 1'b0;
  logic       rd_stb = 1'b0;
  logic [2:0] err_clr = 3'b000;
  logic [7:0] rd_data;
  logic       rx_done, err_ferr, err_perr, err_ovf;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  serial_rx2 u_serial_rx2 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .os_tick(os_tick), .rxd(rxd),
    .par_en(par_en), .par_odd(par_odd), .ovf_imm(ovf_imm), .rd_stb(rd_stb),
    .err_clr(err_clr), .rd_data(rd_data), .rx_done(rx_done), .err_ferr(err_ferr),
    .err_perr(err_perr), .err_ovf(err_ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick_out(input logic v);
    rxd = v;
    repeat (3) @(negedge clk);
    os_tick = 1'b1;
    @(negedge clk);
    os_tick = 1'b0;
  endtask

  task automatic bit_out(input logic v, input logic [15:0] gl);
    for (int k = 0; k < 16; k++) tick_out(v ^ gl[k]);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick_out(1'b1);
  endtask

  task automatic frame_g(input logic [7:0] d, input logic pflip, input logic stopv,
                         input logic [15:0] gl);
    bit_out(1'b0, 16'h0);
    for (int i = 0; i < 8; i++) bit_out(d[i], gl);
    if (par_en) bit_out((^d) ^ par_odd ^ pflip, 16'h0);
    bit_out(stopv, 16'h0);
  endtask

  task automatic frame(input logic [7:0] d);
    frame_g(d, 1'b0, 1'b1, 16'h0);
  endtask

  task automatic rd();
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic clr(input logic [2:0] m);
    @(negedge clk); err_clr = m;
    @(negedge clk); err_clr = 3'b000;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 reset rx_done", rx_done, 0);
    chk("R11 reset errors", {err_ferr, err_perr, err_ovf}, 0);
    idle(20);

    // R3 R7 sweep over parity configurations
    for (int pc = 0; pc < 3; pc++) begin
      par_en = (pc != 0); par_odd = (pc == 2);
      for (int j = 0; j < 16; j++) begin
        d = (j == 0) ? 8'h00 : (j == 1) ? 8'hFF : 8'(j * 53 + pc * 7);
        frame(d);
        idle(2);
        chk("R3 rx_done after frame", rx_done, 1);
        chk("R3 rd_data", rd_data, d);
        chk("R7 no parity error", err_perr, 0);
        chk("R6 no frame error", err_ferr, 0);
        rd();
        chk("R5 empty after read", rx_done, 0);
      end
    end
    par_en = 1'b0; par_odd = 1'b0;

    // R4 back-to-back with single stop
    frame(8'hA5); frame(8'h3C); idle(2);
    chk("R4 first", rd_data, 8'hA5);
    rd();
    chk("R4 second present", rx_done, 1);
    chk("R4 second", rd_data, 8'h3C);
    rd();
    chk("R5 empty", rx_done, 0);

    // R2 majority filter sweep
    for (int g = 0; g < 16; g++) begin
      frame_g(8'h6B, 1'b0, 1'b1, 16'(1 << g));
      idle(2);
      chk("R2 single glitch ignored", rd_data, 8'h6B);
      rd();
    end
    frame_g(8'h6B, 1'b0, 1'b1, 16'h0180); idle(2);
    chk("R2 two of three flip", rd_data, 8'h94);
    rd();
    frame_g(8'h6B, 1'b0, 1'b1, 16'hFC7F); idle(2);
    chk("R2 outside window ignored", rd_data, 8'h6B);
    rd();

    // R1 false start
    bit_out(1'b1, 16'h003F); idle(40);
    chk("R1 false start stores nothing", rx_done, 0);
    frame(8'h96); idle(2);
    chk("R1 receive after false start", rd_data, 8'h96);
    rd();

    // R5 read when empty
    rd();
    chk("R5 empty read no effect", rx_done, 0);
    frame(8'h11); idle(2);
    chk("R5 after empty read", rd_data, 8'h11);
    rd();
    chk("R5 single entry popped", rx_done, 0);

    // R7 parity errors, R8 clears
    par_en = 1'b1; par_odd = 1'b0;
    frame_g(8'h5A, 1'b1, 1'b1, 16'h0); idle(2);
    chk("R7 even parity error", err_perr, 1);
    chk("R7 data kept", rd_data, 8'h5A);
    chk("R8 ferr untouched", err_ferr, 0);
    clr(3'b001);
    chk("R8 other clear leaves perr", err_perr, 1);
    clr(3'b010);
    chk("R8 perr cleared", err_perr, 0);
    rd();
    par_odd = 1'b1;
    frame_g(8'h07, 1'b1, 1'b1, 16'h0); idle(2);
    chk("R7 odd parity error", err_perr, 1);
    rd(); clr(3'b010);
    par_en = 1'b0; par_odd = 1'b0;

    // R6 frame error carried with frame
    frame(8'h21);
    frame_g(8'h33, 1'b0, 1'b0, 16'h0); idle(20);
    chk("R6 not yet visible", err_ferr, 0);
    chk("R6 head", rd_data, 8'h21);
    rd();
    chk("R6 visible at head", err_ferr, 1);
    chk("R6 bad frame stored", rd_data, 8'h33);
    clr(3'b001);
    chk("R8 ferr cleared", err_ferr, 0);
    rd();

    // R9 immediate overflow
    ovf_imm = 1'b1;
    frame(8'h41); frame(8'h42); frame(8'h43); idle(2);
    chk("R9 ovf raised", err_ovf, 1);
    chk("R9 head", rd_data, 8'h41);
    rd();
    chk("R9 second", rd_data, 8'h42);
    rd();
    chk("R9 third dropped", rx_done, 0);
    clr(3'b100);
    chk("R8 ovf cleared", err_ovf, 0);

    // R10 deferred overflow
    ovf_imm = 1'b0;
    frame(8'h51); frame(8'h52); frame(8'h53); idle(2);
    chk("R10 ovf hidden", err_ovf, 0);
    chk("R10 head", rd_data, 8'h51);
    rd();
    chk("R10 ovf after read", err_ovf, 1);
    chk("R10 second", rd_data, 8'h52);
    rd();
    chk("R10 third dropped", rx_done, 0);
    clr(3'b100);

    // R11 disable flush
    par_en = 1'b1;
    frame_g(8'h77, 1'b1, 1'b1, 16'h0); idle(2);
    chk("R11 setup", {rx_done, err_perr}, 2'b11);
    bit_out(1'b0, 16'h0); bit_out(1'b1, 16'h0); bit_out(1'b0, 16'h0);
    @(negedge clk); rx_en = 1'b0; rxd = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 buffer flushed", rx_done, 0);
    chk("R11 errors cleared", {err_ferr, err_perr, err_ovf}, 0);
    rx_en = 1'b1;
    idle(20);
    chk("R11 aborted frame lost", rx_done, 0);
    frame(8'hC3); idle(2);
    chk("R11 receive after enable", rd_data, 8'hC3);
    chk("R11 no stale error", err_perr, 0);
    rd();
    chk("R11 empty", rx_done, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule